// File: doc/BRIEF.md
# USB Endpoint Interrupt Status

This block holds the interrupt status of one USB device endpoint. It watches the byte count of the endpoint FIFO, packet-completion pulses from the packet engine, end-of-frame markers and start-of-frame events. From these it sets seven sticky flags. Software clears any flag by writing a one to its bit. A mask vector then selects which flags drive the single interrupt line.

Transfer end is decided per packet from the endpoint kind, the packet length and the configured maximum packet size. Two flags record events that arrived too close together: a second setup packet while the device-request flag is still up, and a second start of frame while the start-of-frame flag is still up.

Top module: `usb_ep_irq_status`

## Requirements
- R1: Flag bit 0 (FIFO low) is set on every clock edge at which `fifo_count` is strictly below `cfg_alarm`. When the count equals or exceeds the alarm level, the flag is not set.
- R2: For endpoint kinds control (`cfg_ep_type`=0) and bulk (2), a non-setup completed packet sets flag bit 1 (end of transfer) only when its length is zero or less than `cfg_max_pkt`. A full-size packet leaves the flag clear.
- R3: For the interrupt kind (3), every non-setup completed packet sets flag bit 1. For the isochronous kind (1), a non-setup completed packet sets it only when `pkt_ok` is high.
- R4: A completed packet with `pkt_setup` high never sets flag bit 1.
- R5: `eof_mark` sets flag bit 2 (end of frame), independently of flag bit 1. Packet completions never set bit 2.
- R6: A completed packet with `pkt_setup` high sets flag bit 3 (device request).
- R7: A setup packet that completes while flag bit 3 is already set also sets flag bit 4 (multiple device request). This holds even if bit 3 is being cleared in the same cycle. Otherwise bit 4 stays clear.
- R8: `sof_evt` sets flag bit 5 (start of frame). If bit 5 is already set when `sof_evt` arrives, flag bit 6 (missed start of frame) is also set.
- R9: Flags hold until cleared. A cycle with `clr_we` high clears exactly the flags whose `clr_data` bits are one. A flag that is set and cleared in the same cycle ends up set.
- R10: `irq` is high exactly when some flag bit and its `irq_mask` bit are both one. It follows the flags in the same cycle.
- R11: A synchronous active-high `rst` clears all flags, so `irq` reads zero in the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ep_type | input | 2 | Endpoint kind: 0 control, 1 isochronous, 2 bulk, 3 interrupt |
| cfg_max_pkt | input | PKT_W | Maximum packet size in bytes |
| cfg_alarm | input | CNT_W | FIFO low alarm level |
| fifo_count | input | CNT_W | Current FIFO byte count |
| pkt_done | input | 1 | One-cycle pulse: last byte of a packet crossed the FIFO boundary |
| pkt_setup | input | 1 | Qualifies `pkt_done`: the packet was a setup packet |
| pkt_len | input | PKT_W | Byte length of the completed packet |
| pkt_ok | input | 1 | Qualifies `pkt_done`: packet reported error-free |
| eof_mark | input | 1 | End-of-frame marker passed the FIFO interface |
| sof_evt | input | 1 | Start-of-frame event |
| clr_we | input | 1 | Write strobe for write-one-to-clear |
| clr_data | input | 7 | Clear vector, one bit per flag |
| irq_mask | input | 7 | Interrupt enable, one bit per flag |
| flags | output | 7 | Sticky status flags |
| irq | output | 1 | Combined masked interrupt |

## Verification
The collision that matters most is a write-one-to-clear meeting a new set event for the same flag in the same cycle. The bench provokes this in two ways. It clears every flag while the FIFO count sits below the alarm level. It also clears the device-request flag in the same cycle a new setup packet completes. In both cases the flag must read as set afterwards, and in the second case the multiple-request flag must also rise. A related collision, a second start of frame landing on a still-pending first one, is judged by whether only the missed-frame bit appears.

// File: rtl/usb_ep_irq_pkg.sv
package usb_ep_irq_pkg;
   localparam int NFLAG   = 7;
   localparam int F_LOW   = 0;
   localparam int F_EOT   = 1;
   localparam int F_EOF   = 2;
   localparam int F_DREQ  = 3;
   localparam int F_MDREQ = 4;
   localparam int F_SOF   = 5;
   localparam int F_MSOF  = 6;

   typedef enum logic [1:0] {
      EP_CTRL = 2'd0,
      EP_ISO  = 2'd1,
      EP_BULK = 2'd2,
      EP_INTR = 2'd3
   } ep_kind_e;
endpackage

// File: rtl/usb_ep_irq_evt.sv
module usb_ep_irq_evt
   import usb_ep_irq_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int PKT_W = 7
) (
   input  logic [1:0]       ep_type,
   input  logic [PKT_W-1:0] max_pkt,
   input  logic [CNT_W-1:0] alarm,
   input  logic [CNT_W-1:0] count,
   input  logic             done,
   input  logic             setup,
   input  logic [PKT_W-1:0] len,
   input  logic             ok,
   input  logic             eof_in,
   input  logic             sof_in,
   input  logic [NFLAG-1:0] cur,
   output logic [NFLAG-1:0] set_vec
);
   ep_kind_e kind;
   logic     short_pkt;
   logic     data_done;
   logic     eot_hit;
   logic     setup_hit;

   assign kind      = ep_kind_e'(ep_type);
   assign short_pkt = (len == '0) || (len < max_pkt);
   assign data_done = done && !setup;
   assign setup_hit = done && setup;

   always_comb begin
      unique case (kind)
         EP_INTR: eot_hit = data_done;
         EP_ISO:  eot_hit = data_done && ok;
         default: eot_hit = data_done && short_pkt;
      endcase
   end

   always_comb begin
      set_vec          = '0;
      set_vec[F_LOW]   = count < alarm;
      set_vec[F_EOT]   = eot_hit;
      set_vec[F_EOF]   = eof_in;
      set_vec[F_DREQ]  = setup_hit;
      set_vec[F_MDREQ] = setup_hit && cur[F_DREQ];
      set_vec[F_SOF]   = sof_in;
      set_vec[F_MSOF]  = sof_in && cur[F_SOF];
   end
endmodule

// File: rtl/usb_ep_irq_flag.sv
module usb_ep_irq_flag (
   input  logic clk,
   input  logic rst,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk) begin
      if (rst)
         q <= 1'b0;
      else if (set)
         q <= 1'b1;
      else if (clr)
         q <= 1'b0;
   end
endmodule

// File: rtl/usb_ep_irq_status.sv
module usb_ep_irq_status
   import usb_ep_irq_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int PKT_W   = 7,
   parameter bit REG_IRQ = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       cfg_ep_type,
   input  logic [PKT_W-1:0] cfg_max_pkt,
   input  logic [CNT_W-1:0] cfg_alarm,
   input  logic [CNT_W-1:0] fifo_count,
   input  logic             pkt_done,
   input  logic             pkt_setup,
   input  logic [PKT_W-1:0] pkt_len,
   input  logic             pkt_ok,
   input  logic             eof_mark,
   input  logic             sof_evt,
   input  logic             clr_we,
   input  logic [NFLAG-1:0] clr_data,
   input  logic [NFLAG-1:0] irq_mask,
   output logic [NFLAG-1:0] flags,
   output logic             irq
);
   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("CNT_W out of range");
      end
      if (PKT_W < 1 || PKT_W > 11) begin : g_bad_pkt
         $error("PKT_W out of range");
      end
   endgenerate

   logic [NFLAG-1:0] set_vec;
   logic [NFLAG-1:0] clr_vec;
   logic             irq_any;

   assign clr_vec = clr_we ? clr_data : '0;

   usb_ep_irq_evt #(.CNT_W(CNT_W), .PKT_W(PKT_W)) u_evt (
      .ep_type (cfg_ep_type),
      .max_pkt (cfg_max_pkt),
      .alarm   (cfg_alarm),
      .count   (fifo_count),
      .done    (pkt_done),
      .setup   (pkt_setup),
      .len     (pkt_len),
      .ok      (pkt_ok),
      .eof_in  (eof_mark),
      .sof_in  (sof_evt),
      .cur     (flags),
      .set_vec (set_vec)
   );

   generate
      for (genvar i = 0; i < NFLAG; i++) begin : g_flag
         usb_ep_irq_flag u_flag (
            .clk (clk),
            .rst (rst),
            .set (set_vec[i]),
            .clr (clr_vec[i]),
            .q   (flags[i])
         );
      end
   endgenerate

   assign irq_any = |(flags & irq_mask);

   generate
      if (REG_IRQ) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (rst) irq_q <= 1'b0;
            else     irq_q <= irq_any;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_any;
      end
   endgenerate
endmodule

// File: rtl/usb_ep_irq_chk.sv
module usb_ep_irq_chk
   import usb_ep_irq_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int PKT_W = 7
) (
   input logic             clk,
   input logic             rst,
   input logic [CNT_W-1:0] cfg_alarm,
   input logic [CNT_W-1:0] fifo_count,
   input logic             pkt_done,
   input logic             pkt_setup,
   input logic             eof_mark,
   input logic             sof_evt,
   input logic             clr_we,
   input logic [NFLAG-1:0] flags
);
   AST_LOW_SET: assert property (@(posedge clk) disable iff (rst)
      (fifo_count < cfg_alarm) |=> flags[F_LOW]); // R1
   AST_SETUP_NO_EOT: assert property (@(posedge clk) disable iff (rst)
      (pkt_done && pkt_setup && !flags[F_EOT]) |=> !flags[F_EOT]); // R4
   AST_EOF_SET: assert property (@(posedge clk) disable iff (rst)
      eof_mark |=> flags[F_EOF]); // R5
   AST_DREQ_SET: assert property (@(posedge clk) disable iff (rst)
      (pkt_done && pkt_setup) |=> flags[F_DREQ]); // R6
   AST_MDREQ_SET: assert property (@(posedge clk) disable iff (rst)
      (pkt_done && pkt_setup && flags[F_DREQ]) |=> flags[F_MDREQ]); // R7
   AST_MSOF_SET: assert property (@(posedge clk) disable iff (rst)
      (sof_evt && flags[F_SOF]) |=> flags[F_MSOF]); // R8
   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!clr_we && flags[F_EOT]) |=> flags[F_EOT]); // R9
endmodule

bind usb_ep_irq_status usb_ep_irq_chk #(.CNT_W(CNT_W), .PKT_W(PKT_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .cfg_alarm  (cfg_alarm),
   .fifo_count (fifo_count),
   .pkt_done   (pkt_done),
   .pkt_setup  (pkt_setup),
   .eof_mark   (eof_mark),
   .sof_evt    (sof_evt),
   .clr_we     (clr_we),
   .flags      (flags)
);

// File: tb/usb_ep_irq_status_tb.sv
`timescale 1ns/1ps
module usb_ep_irq_status_tb;
   localparam int CW = 3;
   localparam int PW = 3;
   localparam int NF = 7;

   logic          clk = 1'b0;
   logic          rst;
   logic [1:0]    cfg_ep_type;
   logic [PW-1:0] cfg_max_pkt;
   logic [CW-1:0] cfg_alarm;
   logic [CW-1:0] fifo_count;
   logic          pkt_done, pkt_setup, pkt_ok, eof_mark, sof_evt, clr_we;
   logic [PW-1:0] pkt_len;
   logic [NF-1:0] clr_data, irq_mask, flags;
   logic          irq;

   int n_run  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   usb_ep_irq_status #(.CNT_W(CW), .PKT_W(PW)) u_dut (
      .clk(clk), .rst(rst), .cfg_ep_type(cfg_ep_type), .cfg_max_pkt(cfg_max_pkt),
      .cfg_alarm(cfg_alarm), .fifo_count(fifo_count), .pkt_done(pkt_done),
      .pkt_setup(pkt_setup), .pkt_len(pkt_len), .pkt_ok(pkt_ok), .eof_mark(eof_mark),
      .sof_evt(sof_evt), .clr_we(clr_we), .clr_data(clr_data), .irq_mask(irq_mask),
      .flags(flags), .irq(irq)
   );

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle();
      pkt_done = 0; pkt_setup = 0; pkt_ok = 0; pkt_len = '0;
      eof_mark = 0; sof_evt = 0; clr_we = 0; clr_data = '0;
   endtask

   // drive at negedge, let one posedge pass, return at next negedge
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   task automatic clear_all();
      clr_we = 1; clr_data = '1;
      step();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      idle();
      rst = 1; cfg_ep_type = 2'd2; cfg_max_pkt = 3'd4; cfg_alarm = '0;
      fifo_count = 3'd7; irq_mask = '1;
      @(negedge clk);
      step();
      // R11: reset state
      check("R11 flags after reset", flags, 0);
      check("R11 irq after reset", irq, 0);
      rst = 0;
      step();
      check("R11 flags idle", flags, 0);

      // R1 and R9: sweep alarm and count; clear collides with level set
      for (int a = 0; a < 8; a++) begin
         for (int c = 0; c < 8; c++) begin
            cfg_alarm = a[CW-1:0]; fifo_count = c[CW-1:0];
            clear_all();
            check("R1 R9 fifo low level vs clear", flags[0], (c < a) ? 1 : 0);
         end
      end
      cfg_alarm = '0; fifo_count = 3'd7;
      clear_all();

      // R2 R3 R4 R6: sweep endpoint kind, length, setup, ok
      for (int t = 0; t < 4; t++) begin
         for (int l = 0; l < 8; l++) begin
            for (int s = 0; s < 2; s++) begin
               for (int o = 0; o < 2; o++) begin
                  int exp_eot;
                  cfg_ep_type = t[1:0];
                  clear_all();
                  pkt_done = 1; pkt_setup = s[0]; pkt_len = l[PW-1:0]; pkt_ok = o[0];
                  step();
                  if (s == 1)      exp_eot = 0;
                  else if (t == 3) exp_eot = 1;
                  else if (t == 1) exp_eot = o;
                  else             exp_eot = (l < 4) ? 1 : 0;
                  check("R2 R3 R4 eot decode", flags[1], exp_eot);
                  check("R6 devreq on setup", flags[3], s);
                  check("R5 no eof from packet", flags[2], 0);
               end
            end
         end
      end
      cfg_ep_type = 2'd2;
      clear_all();

      // R5: eof marker alone
      eof_mark = 1;
      step();
      check("R5 eof set alone", flags, 7'h04);
      clear_all();

      // R7: two setups in a row
      pkt_done = 1; pkt_setup = 1; step();
      pkt_done = 1; pkt_setup = 1; step();
      check("R7 second setup sets mdevreq", flags, 7'h18);
      clear_all();
      // R7: setup, clear devreq, setup -> no multiple flag
      pkt_done = 1; pkt_setup = 1; step();
      clr_we = 1; clr_data = 7'h08; step();
      check("R9 devreq cleared", flags, 0);
      pkt_done = 1; pkt_setup = 1; step();
      check("R7 no mdevreq after clear", flags, 7'h08);
      // R7 R9: setup collides with clear of devreq
      pkt_done = 1; pkt_setup = 1; clr_we = 1; clr_data = 7'h08; step();
      check("R7 R9 setup with clear same cycle", flags, 7'h18);
      clear_all();

      // R8: sof twice, then sof/clear/sof
      sof_evt = 1; step();
      check("R8 sof pending", flags, 7'h20);
      sof_evt = 1; step();
      check("R8 missed sof", flags, 7'h60);
      clear_all();
      sof_evt = 1; step();
      clr_we = 1; clr_data = 7'h20; step();
      sof_evt = 1; step();
      check("R8 no missed sof after clear", flags, 7'h20);
      clear_all();

      // R9: stickiness and selective clear
      cfg_ep_type = 2'd3;
      pkt_done = 1; pkt_len = 3'd4; step();
      eof_mark = 1; step();
      pkt_done = 1; pkt_setup = 1; step();
      step(); step();
      check("R9 flags hold", flags, 7'h0E);
      clr_we = 1; clr_data = 7'h02; step();
      check("R9 selective clear", flags, 7'h0C);
      pkt_done = 1; pkt_len = 3'd1; step();
      check("R9 eot reset", flags, 7'h0E);

      // R10: mask sweep over known flags 0x0E
      for (int m = 0; m < 128; m++) begin
         irq_mask = m[NF-1:0];
         #1;
         check("R10 masked irq", irq, ((m & 7'h0E) != 0) ? 1 : 0);
      end
      irq_mask = '1;

      // R11: reset midstream
      rst = 1; step(); rst = 0;
      check("R11 midstream reset flags", flags, 0);
      check("R11 midstream reset irq", irq, 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule